// File: doc/BRIEF.md
# Floating-Point Condition Branch Evaluator

This block resolves the conditional control-flow instructions that test the floating-point condition state. Each request carries the two opcode bytes, an 8-bit displacement, the address of the instruction, the loop address register and the four floating-point condition flags: unordered, less, greater and equal. It also carries a unit-enable bit. The block decides whether control transfers and returns the address of the next instruction.

There are two instruction forms. The relative branch adds a sign-extended displacement to its own address. The loop form jumps to the loop address register minus four. The low nibble of the second opcode byte selects one of fourteen predicates. A predicate is taken when any flag it names is set. When the unit is disabled, a well-formed request raises an exception and never transfers control. Malformed encodings are flagged as invalid.

The block is a single stage. The request is sampled on the clock edge where `in_valid` is high. The result is presented, with `out_valid`, for the following cycle.

Top module: `fp_cond_redirect`

## Requirements
- R1: `cond_flags` is ordered bit 3 = unordered (U), bit 2 = less (L), bit 1 = greater (G), bit 0 = equal (E). The selector is the low nibble of `op_b1`, and it names these flag sets: 0 E, 1 U|L|G, 2 G, 3 G|E, 4 L, 5 L|E, 6 U, 7 L|G, 8 L|E|G, 9 U|G, A U|G|E, B U|L, C U|L|E, D U|E. `taken` is 1 exactly when at least one flag of the selected set is 1.
- R2: A branch is `op_b0` = 0xF8 with `op_b1` in 0xD0..0xDD. When it is taken, `next_pc` = `inst_addr` + the sign-extended `disp`.
- R3: A loop is `op_b0` = 0xF0 with `op_b1` in 0xD0..0xDD, and `disp` is ignored. When it is taken, `next_pc` = `loop_addr` − 4.
- R4: When a well-formed, enabled request is not taken, `next_pc` = `inst_addr` + 3 for a branch, or `inst_addr` + 2 for a loop.
- R5: When a well-formed request arrives with `fpu_en` = 0, the result is `fpu_off_exc` = 1, `taken` = 0, `bad_op` = 0 and `next_pc` = `inst_addr`, whatever the flags are.
- R6: A request is invalid when `op_b0` is neither 0xF0 nor 0xF8, when the high nibble of `op_b1` is not 0xD, or when its low nibble is 0xE or 0xF. An invalid request gives `bad_op` = 1, `taken` = 0, `fpu_off_exc` = 0 and `next_pc` = `inst_addr`, even when `fpu_en` = 0.
- R7: All address arithmetic wraps modulo 2^32.
- R8: After reset, `out_valid`, `taken`, `fpu_off_exc`, `bad_op` and `next_pc` are 0. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In a cycle without `in_valid`, the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte (predicate selector in low nibble) |
| disp | input | 8 | Signed branch displacement |
| inst_addr | input | 32 | Address of the instruction |
| loop_addr | input | 32 | Loop address register |
| cond_flags | input | 4 | {U, L, G, E} condition flags |
| fpu_en | input | 1 | Floating-point unit enabled |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Control transfers |
| next_pc | output | 32 | Address of next instruction |
| fpu_off_exc | output | 1 | Unit-disabled exception |
| bad_op | output | 1 | Invalid encoding |

## Verification
A wrong predicate mask, or a wrong decode of the selector, shows up as a wrong `taken` value and a wrong `next_pc`. It appears in the very next cycle for some flag pattern. Sweeping every selector across all sixteen flag combinations therefore exposes such a fault at once. A mistake in target selection or in the wrap-around arithmetic is exposed by the same single-cycle result, using addresses placed close to the 32-bit boundary. A fault in the output register's enable shows up as a changed result in an idle cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {FORM_NONE, FORM_BRANCH, FORM_LOOP} form_e;

  localparam logic [7:0] OPC_BRANCH = 8'hF8;
  localparam logic [7:0] OPC_LOOP   = 8'hF0;
  localparam logic [3:0] OPC_GROUP  = 4'hD;
  localparam logic [3:0] SEL_LAST   = 4'hD;

  // Flag positions inside the condition vector.
  localparam int FLG_U = 3;
  localparam int FLG_L = 2;
  localparam int FLG_G = 1;
  localparam int FLG_E = 0;

  // Flags named by each predicate selector; zero for unused selectors.
  function automatic logic [3:0] pred_mask(input logic [3:0] sel);
    logic [3:0] m;
    m = '0;
    case (sel)
      4'h0: m[FLG_E] = 1'b1;
      4'h1: begin m[FLG_U] = 1'b1; m[FLG_L] = 1'b1; m[FLG_G] = 1'b1; end
      4'h2: m[FLG_G] = 1'b1;
      4'h3: begin m[FLG_G] = 1'b1; m[FLG_E] = 1'b1; end
      4'h4: m[FLG_L] = 1'b1;
      4'h5: begin m[FLG_L] = 1'b1; m[FLG_E] = 1'b1; end
      4'h6: m[FLG_U] = 1'b1;
      4'h7: begin m[FLG_L] = 1'b1; m[FLG_G] = 1'b1; end
      4'h8: begin m[FLG_L] = 1'b1; m[FLG_E] = 1'b1; m[FLG_G] = 1'b1; end
      4'h9: begin m[FLG_U] = 1'b1; m[FLG_G] = 1'b1; end
      4'hA: begin m[FLG_U] = 1'b1; m[FLG_G] = 1'b1; m[FLG_E] = 1'b1; end
      4'hB: begin m[FLG_U] = 1'b1; m[FLG_L] = 1'b1; end
      4'hC: begin m[FLG_U] = 1'b1; m[FLG_L] = 1'b1; m[FLG_E] = 1'b1; end
      4'hD: begin m[FLG_U] = 1'b1; m[FLG_E] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] op_b0,
  input  logic [OPC_W-1:0] op_b1,
  output form_e            form,
  output logic [3:0]       sel,
  output logic             well_formed
);
  localparam int HI = OPC_W - 1;

  logic group_ok;
  logic sel_ok;

  assign sel      = op_b1[3:0];
  assign group_ok = (op_b1[HI -: 4] == OPC_GROUP);
  assign sel_ok   = (sel <= SEL_LAST);

  always_comb begin
    form = FORM_NONE;
    if (group_ok && sel_ok) begin
      if (op_b0 == OPC_BRANCH)    form = FORM_BRANCH;
      else if (op_b0 == OPC_LOOP) form = FORM_LOOP;
    end
  end

  assign well_formed = (form != FORM_NONE);
endmodule

// File: rtl/fpc_cond.sv
module fpc_cond
  import fpc_pkg::*;
#(
  parameter int NFLAGS = 4
) (
  input  logic [3:0]        sel,
  input  logic [NFLAGS-1:0] flags,
  output logic              hit
);
  logic [NFLAGS-1:0] mask;
  logic [NFLAGS-1:0] term;

  assign mask = pred_mask(sel);

  for (genvar i = 0; i < NFLAGS; i++) begin : g_term
    assign term[i] = mask[i] & flags[i];
  end

  assign hit = |term;
endmodule

// File: rtl/fpc_target.sv
module fpc_target
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 8,
  parameter int BR_LEN    = 3,
  parameter int LOOP_LEN  = 2,
  parameter int LOOP_BIAS = 4
) (
  input  form_e              form,
  input  logic               well_formed,
  input  logic               hit,
  input  logic               fpu_en,
  input  logic [ADDR_W-1:0]  inst_addr,
  input  logic [DISP_W-1:0]  disp,
  input  logic [ADDR_W-1:0]  loop_addr,
  output logic               taken,
  output logic               exc,
  output logic               bad,
  output logic [ADDR_W-1:0]  next_pc
);
  localparam logic [ADDR_W-1:0] BR_STEP   = ADDR_W'(BR_LEN);
  localparam logic [ADDR_W-1:0] LOOP_STEP = ADDR_W'(LOOP_LEN);
  localparam logic [ADDR_W-1:0] BIAS      = ADDR_W'(LOOP_BIAS);

  function automatic logic [ADDR_W-1:0] rel_target(
    input logic [ADDR_W-1:0] base, input logic [DISP_W-1:0] d);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    return base + ext;
  endfunction

  function automatic logic [ADDR_W-1:0] loop_target(input logic [ADDR_W-1:0] lar);
    return lar - BIAS;
  endfunction

  function automatic logic [ADDR_W-1:0] fall_through(
    input logic [ADDR_W-1:0] base, input logic is_loop);
    return base + (is_loop ? LOOP_STEP : BR_STEP);
  endfunction

  logic run;
  assign bad  = !well_formed;
  assign exc  = well_formed && !fpu_en;
  assign run  = well_formed && fpu_en;
  assign taken = run && hit;

  always_comb begin
    next_pc = inst_addr;
    if (run) begin
      if (hit) next_pc = (form == FORM_LOOP) ? loop_target(loop_addr)
                                             : rel_target(inst_addr, disp);
      else     next_pc = fall_through(inst_addr, form == FORM_LOOP);
    end
  end
endmodule

// File: rtl/fp_cond_redirect.sv
module fp_cond_redirect
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8,
  parameter int OPC_W  = 8,
  parameter int NFLAGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  op_b0,
  input  logic [OPC_W-1:0]  op_b1,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] inst_addr,
  input  logic [ADDR_W-1:0] loop_addr,
  input  logic [NFLAGS-1:0] cond_flags,
  input  logic              fpu_en,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              fpu_off_exc,
  output logic              bad_op
);
  form_e             dec_form;
  logic [3:0]        dec_sel;
  logic              dec_ok;
  logic              cond_hit;
  logic              res_taken, res_exc, res_bad;
  logic [ADDR_W-1:0] res_pc;

  fpc_decode #(.OPC_W(OPC_W)) u_dec (
    .op_b0(op_b0), .op_b1(op_b1),
    .form(dec_form), .sel(dec_sel), .well_formed(dec_ok)
  );

  fpc_cond #(.NFLAGS(NFLAGS)) u_cond (
    .sel(dec_sel), .flags(cond_flags), .hit(cond_hit)
  );

  fpc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .form(dec_form), .well_formed(dec_ok), .hit(cond_hit), .fpu_en(fpu_en),
    .inst_addr(inst_addr), .disp(disp), .loop_addr(loop_addr),
    .taken(res_taken), .exc(res_exc), .bad(res_bad), .next_pc(res_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      taken       <= 1'b0;
      next_pc     <= '0;
      fpu_off_exc <= 1'b0;
      bad_op      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken       <= res_taken;
        next_pc     <= res_pc;
        fpu_off_exc <= res_exc;
        bad_op      <= res_bad;
      end
    end
  end
endmodule

// File: rtl/fpc_redirect_chk.sv
module fpc_redirect_chk #(
  parameter int ADDR_W = 32,
  parameter int OPC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPC_W-1:0]  op_b0,
  input logic              fpu_en,
  input logic [ADDR_W-1:0] inst_addr,
  input logic [ADDR_W-1:0] loop_addr,
  input logic              dec_ok,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              fpu_off_exc,
  input logic              bad_op
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken))); // R8
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, fpu_off_exc, bad_op})); // R5
  AST_DISABLED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_ok && !fpu_en) |=> (fpu_off_exc && next_pc == $past(inst_addr))); // R5
  AST_INVALID_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_ok) |=> (bad_op && next_pc == $past(inst_addr))); // R6
  AST_LOOP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_ok && fpu_en && op_b0 == 8'hF0) |=>
      (taken ? (next_pc == $past(loop_addr) - 32'd4)
             : (next_pc == $past(inst_addr) + 32'd2))); // R3
endmodule

bind fp_cond_redirect fpc_redirect_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/fp_cond_redirect_bench.sv
module fp_cond_redirect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  op_b0 = '0, op_b1 = '0, disp = '0;
  logic [31:0] inst_addr = '0, loop_addr = '0;
  logic [3:0]  cond_flags = '0;
  logic        fpu_en = 1'b0;
  logic        out_valid, taken, fpu_off_exc, bad_op;
  logic [31:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_cond_redirect u_fp_cond_redirect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_b0(op_b0), .op_b1(op_b1),
    .disp(disp), .inst_addr(inst_addr), .loop_addr(loop_addr),
    .cond_flags(cond_flags), .fpu_en(fpu_en), .out_valid(out_valid),
    .taken(taken), .next_pc(next_pc), .fpu_off_exc(fpu_off_exc), .bad_op(bad_op)
  );

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  d;
    logic [31:0] addr;
    logic [31:0] lar;
    logic [3:0]  fl;
    logic        en;
    logic        x_taken;
    logic        x_exc;
    logic        x_bad;
    logic [31:0] x_pc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'hF8, 8'hD0, 8'h05, 32'h100, 32'h0, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 32'h105, 4'd2},      // R2
    '{8'hF8, 8'hD2, 8'hF0, 32'h100, 32'h0, 4'b0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'hF0, 4'd2},       // R2 negative
    '{8'hF8, 8'hD4, 8'h10, 32'h100, 32'h0, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 32'h103, 4'd4},      // R4
    '{8'hF0, 8'hD6, 8'h33, 32'h200, 32'h80, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h7C, 4'd3},      // R3
    '{8'hF0, 8'hD7, 8'h00, 32'h200, 32'h80, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 32'h202, 4'd4},     // R4
    '{8'hF8, 8'hD8, 8'h7F, 32'hFFFFFFF0, 32'h0, 4'b0100, 1'b1, 1'b1, 1'b0, 1'b0, 32'h6F, 4'd7},  // R7
    '{8'hF0, 8'hDD, 8'h00, 32'h40, 32'h2, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFE, 4'd7},  // R7
    '{8'hF0, 8'hD1, 8'h00, 32'hFFFFFFFF, 32'h0, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1, 4'd7},   // R7
    '{8'hF8, 8'hD3, 8'h00, 32'h300, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 32'h300, 4'd5},      // R5
    '{8'hF8, 8'hDE, 8'h04, 32'h400, 32'h0, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1, 32'h400, 4'd6},      // R6
    '{8'hF0, 8'hC1, 8'h00, 32'h500, 32'h0, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1, 32'h500, 4'd6},      // R6
    '{8'h12, 8'hDD, 8'h00, 32'h600, 32'h0, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1, 32'h600, 4'd6},      // R6
    '{8'hF8, 8'hDF, 8'h00, 32'h700, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 32'h700, 4'd6}       // R6 priority
  };

  // Predicate restated from R1 with named flags.
  function automatic logic pred(input int s, input logic [3:0] f);
    logic u, l, g, e;
    {u, l, g, e} = f;
    case (s)
      0: return e;           1: return u | l | g;
      2: return g;           3: return g | e;
      4: return l;           5: return l | e;
      6: return u;           7: return l | g;
      8: return l | e | g;   9: return u | g;
      10: return u | g | e;  11: return u | l;
      12: return u | l | e;  13: return u | e;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] d,
                       input logic [31:0] a, input logic [31:0] lr,
                       input logic [3:0] fl, input logic en);
    @(negedge clk);
    op_b0 = b0; op_b1 = b1; disp = d; inst_addr = a; loop_addr = lr;
    cond_flags = fl; fpu_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    // R8: reset state
    #12;
    check("R8", "reset out_valid", {31'b0, out_valid}, 32'h0);
    check("R8", "reset next_pc", next_pc, 32'h0);
    check("R8", "reset flags", {29'b0, taken, fpu_off_exc, bad_op}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk (R2..R7)
    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VECS[i].req);
      issue(VECS[i].b0, VECS[i].b1, VECS[i].d, VECS[i].addr, VECS[i].lar,
            VECS[i].fl, VECS[i].en);
      check(r, $sformatf("vec %0d out_valid", i), {31'b0, out_valid}, 32'h1);
      check(r, $sformatf("vec %0d taken", i), {31'b0, taken}, {31'b0, VECS[i].x_taken});
      check(r, $sformatf("vec %0d exc", i), {31'b0, fpu_off_exc}, {31'b0, VECS[i].x_exc});
      check(r, $sformatf("vec %0d bad", i), {31'b0, bad_op}, {31'b0, VECS[i].x_bad});
      check(r, $sformatf("vec %0d next_pc", i), next_pc, VECS[i].x_pc);
    end

    // R8: idle cycle holds result, out_valid low
    @(negedge clk);
    check("R8", "idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R8", "idle next_pc hold", next_pc, 32'h700);

    // R1: every selector against every flag pattern, branch form
    for (int s = 0; s < 14; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic exp_t;
        exp_t = pred(s, 4'(f));
        issue(8'hF8, 8'hD0 | 8'(s), 8'h10, 32'h1000, 32'h0, 4'(f), 1'b1);
        check("R1", $sformatf("sel %0d flags %b taken", s, f[3:0]), {31'b0, taken},
              {31'b0, exp_t});
        check("R1", $sformatf("sel %0d flags %b pc", s, f[3:0]), next_pc,
              exp_t ? 32'h1010 : 32'h1003);
      end
    end

    // R3: loop ignores disp
    issue(8'hF0, 8'hD6, 8'h80, 32'h2000, 32'h3000, 4'b1000, 1'b1);
    check("R3", "loop ignores disp", next_pc, 32'h2FFC);

    // R5: disabled with no flags, loop form
    issue(8'hF0, 8'hD0, 8'h00, 32'h2100, 32'h3000, 4'b0000, 1'b0);
    check("R5", "disabled loop exc", {31'b0, fpu_off_exc}, 32'h1);
    check("R5", "disabled loop pc", next_pc, 32'h2100);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule